// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block turns a stereo audio bit stream into parallel sample pairs. It takes a data line, a bit clock and a left/right (or frame) clock from an external master. All three are brought into the system clock domain and the bit clock's rising edge is used as a one-cycle enable, so every register runs on the system clock. The system clock must run at least several times faster than the bit clock.

At run time a select input picks one of four alignments: right justified, I2S, or a frame-pulse mode with the left word starting either one or two bit clocks after the pulse. A second select sets the sample word length. When the right-channel word of a pair is finished, both words appear together on the outputs with a strobe one system clock long. The block is a slave only and generates no clocks.

Top module: `audrx_serial_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `valid_out` is 0 and both word outputs are zero.
- R2: `valid_out` is high for exactly one system clock per stereo pair. `left_out` and `right_out` change only in the cycle `valid_out` is high, and they change together.
- R3: Format code `fmt_sel`=0 (right justified): the left/right clock is high for the left word and low for the right word. A word's LSB is the bit sampled on the last bit-clock rise before the left/right clock changes level. A pair is output after the right word ends, which is when the left/right clock rises again.
- R4: In right-justified format, a half-frame may hold more bit clocks than the word length. Only the last N bits before the level change are kept and earlier bits are ignored.
- R5: Format code 1 (I2S): the left/right clock is low for the left word and high for the right word. The MSB is the bit sampled on the second bit-clock rise after a level change.
- R6: In I2S format, bits after the first N of a word are discarded. If fewer than N bits arrive before the next level change, the missing low-order bits are zero. The bit on the first rise after a change still belongs to the previous word.
- R7: Format code 3 (frame-pulse, early): the left MSB is the bit sampled on the first bit-clock rise that sees the frame pulse high. The right word's MSB follows directly after the left LSB.
- R8: Format code 2 (frame-pulse, late): the left MSB is the bit sampled on the second rise after the pulse goes high. The right word follows directly after the left LSB.
- R9: In both frame-pulse formats, bit clocks after the right LSB are ignored until the next pulse rises. The pulse may be any width that leaves at least two low bit clocks before the next pulse.
- R10: `wlen_sel` codes 0, 1, 2 and 3 select N = 16, 20, 24 and 32 bits. A word appears in bits N-1:0 of its output, and all higher bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock from the master, asynchronous |
| lrclk_in | input | 1 | Left/right level or frame pulse, changes on bit-clock fall |
| data_in | input | 1 | Serial data, changes on bit-clock fall |
| fmt_sel | input | 2 | Alignment: 0 right justified, 1 I2S, 2 late pulse, 3 early pulse |
| wlen_sel | input | 2 | Word length code: 16/20/24/32 bits |
| left_out | output | WMAX | Last completed left word, right aligned |
| right_out | output | WMAX | Last completed right word, right aligned |
| valid_out | output | 1 | One-cycle strobe when a new pair is on the outputs |

## Verification
Right-justified streams are sent with half-frames exactly N bits long and with several extra leading junk bits. This shows that the engine keeps the final N bits and does not keep the first N. I2S streams are sent with half-frames equal to, longer than and shorter than N. These runs separate the one-bit delayed MSB, the discarding of surplus bits and the zero padding at the LSB end. Frame-pulse streams in both the early and late variants use random pulse widths and idle gaps. A one-bit alignment error, or an idle bit taken into the next word, changes every expected word. Random words at each length, plus alternating and edge-bit directed words, show whether the high bits are cleared.

// File: rtl/audrx_pkg.sv
// Shared types and helpers for the audio serial receiver.
// Assumes word lengths never exceed 64 bits.
package audrx_pkg;

    typedef enum logic [1:0] {
        FMT_RJ   = 2'd0,
        FMT_I2S  = 2'd1,
        FMT_DSPA = 2'd2,
        FMT_DSPB = 2'd3
    } fmt_e;

    // Map a word-length code to a bit count.
    function automatic int unsigned wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

    // Build a mask with the low n bits set.
    function automatic logic [63:0] low_mask(input int unsigned n);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/audrx_edge.sv
// Synchroniser and bit-clock edge detector.
// Brings bit clock, left/right clock and data into the system clock
// domain through SYNC flops each. It raises tick for one cycle per
// bit-clock rise. lr_s and d_s are the values aligned with that rise.
// Assumes each bit-clock phase lasts at least two system clocks.
module audrx_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic lrclk_in,
    input  logic data_in,
    output logic tick,
    output logic lr_s,
    output logic d_s
);
    localparam int TOP = SYNC;

    logic [TOP:0] bclk_sh;
    logic [TOP:0] lr_sh;
    logic [TOP:0] d_sh;

    // Shift all three inputs through matched synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sh <= '0;
            lr_sh   <= '0;
            d_sh    <= '0;
        end else begin
            bclk_sh <= {bclk_sh[TOP-1:0], bclk_in};
            lr_sh   <= {lr_sh[TOP-1:0], lrclk_in};
            d_sh    <= {d_sh[TOP-1:0], data_in};
        end
    end

    // Rising-edge enable and the samples that go with it.
    always_comb begin
        tick = bclk_sh[TOP-1] & ~bclk_sh[TOP];
        lr_s = lr_sh[TOP-1];
        d_s  = d_sh[TOP-1];
    end

endmodule

// File: rtl/audrx_shift.sv
// Shift engine shared by all four alignments.
// On each bit-clock tick it takes one bit. It reports each finished
// word on close_* for one cycle (chan 0 = left, 1 = right).
// Right justified: a running shift register is cut at the level change.
// I2S and frame-pulse: a counter places bits MSB first from a start point.
// Surplus bits are dropped and missing bits stay zero.
// Assumes fmt and wlen are held steady while a stream is running.
module audrx_shift
    import audrx_pkg::*;
#(
    parameter int WMAX = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            lr,
    input  logic            d,
    input  fmt_e            fmt,
    input  logic [1:0]      wlen,
    output logic            close_stb,
    output logic            close_chan,
    output logic [WMAX-1:0] close_word
);
    localparam int CW = $clog2(WMAX + 1);

    logic [CW-1:0]   nbits;
    logic [CW-1:0]   cnt;
    logic [WMAX-1:0] nmask;
    logic [WMAX-1:0] sr;
    logic [WMAX-1:0] acc;
    logic [WMAX-1:0] ins_word;
    logic [WMAX-1:0] msb_word;
    logic            seen;
    logic            lr_prev;
    logic            chan;
    logic            active;
    logic            pend;
    logic            pend_chan;
    logic            lr_edge;
    logic            frame_rise;
    logic            last_bit;
    logic            is_dsp;

    // Decode word length, edges and the word with the current bit inserted.
    always_comb begin
        if (wlen_bits(wlen) > WMAX) nbits = CW'(WMAX);
        else                        nbits = CW'(wlen_bits(wlen));
        nmask      = WMAX'(low_mask(int'(nbits)));
        lr_edge    = seen && (lr != lr_prev);
        frame_rise = lr_edge && lr;
        last_bit   = (cnt == nbits - 1'b1);
        is_dsp     = (fmt == FMT_DSPA) || (fmt == FMT_DSPB);
        msb_word   = WMAX'(d) << (nbits - 1'b1);
        ins_word   = acc;
        if (cnt < nbits) ins_word = acc | (WMAX'(d) << (nbits - cnt - 1'b1));
    end

    // Per-tick bit capture and word framing for the selected format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            close_stb  <= 1'b0;
            close_chan <= 1'b0;
            close_word <= '0;
            seen       <= 1'b0;
            lr_prev    <= 1'b0;
            sr         <= '0;
            acc        <= '0;
            cnt        <= '0;
            chan       <= 1'b0;
            active     <= 1'b0;
            pend       <= 1'b0;
            pend_chan  <= 1'b0;
        end else begin
            close_stb <= 1'b0;
            if (tick) begin
                seen    <= 1'b1;
                lr_prev <= lr;
                sr      <= {sr[WMAX-2:0], d};
                if (fmt == FMT_RJ) begin
                    if (lr_edge) begin
                        close_stb  <= 1'b1;
                        close_chan <= ~lr_prev;
                        close_word <= sr & nmask;
                    end
                end else if ((fmt == FMT_I2S && lr_edge) || (is_dsp && frame_rise)) begin
                    if (active) begin
                        close_stb  <= 1'b1;
                        close_chan <= chan;
                        close_word <= (fmt == FMT_I2S) ? ins_word : acc;
                    end
                    if (fmt == FMT_DSPB) begin
                        acc    <= msb_word;
                        cnt    <= CW'(1);
                        chan   <= 1'b0;
                        active <= 1'b1;
                        pend   <= 1'b0;
                    end else begin
                        active    <= 1'b0;
                        pend      <= 1'b1;
                        pend_chan <= (fmt == FMT_I2S) ? lr : 1'b0;
                    end
                end else if (pend) begin
                    acc    <= msb_word;
                    cnt    <= CW'(1);
                    chan   <= pend_chan;
                    active <= 1'b1;
                    pend   <= 1'b0;
                end else if (active) begin
                    if (last_bit) begin
                        close_stb  <= 1'b1;
                        close_chan <= chan;
                        close_word <= ins_word;
                        if (is_dsp && !chan) begin
                            chan <= 1'b1;
                            cnt  <= '0;
                            acc  <= '0;
                        end else begin
                            active <= 1'b0;
                        end
                    end else begin
                        acc <= ins_word;
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/audrx_pair.sv
// Stereo pair assembler.
// Holds a finished left word until its right partner closes. Then it
// loads both outputs and strobes valid for one cycle. A right word
// with no left word held is dropped.
module audrx_pair #(
    parameter int WMAX = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            close_stb,
    input  logic            close_chan,
    input  logic [WMAX-1:0] close_word,
    output logic [WMAX-1:0] left_out,
    output logic [WMAX-1:0] right_out,
    output logic            valid_out
);
    logic [WMAX-1:0] left_hold;
    logic            have_left;

    // Pair words and present them together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_out  <= '0;
            right_out <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= 1'b0;
            if (close_stb) begin
                if (!close_chan) begin
                    left_hold <= close_word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_out  <= left_hold;
                    right_out <= close_word;
                    valid_out <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/audrx_serial_rx.sv
// Top level of the multi-format stereo audio serial receiver (slave).
// Chain: synchroniser/edge detect, shift engine, pair assembler.
// Assumes the system clock is at least four times the bit clock.
module audrx_serial_rx
    import audrx_pkg::*;
#(
    parameter int WMAX = 32,
    parameter int SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk_in,
    input  logic            lrclk_in,
    input  logic            data_in,
    input  logic [1:0]      fmt_sel,
    input  logic [1:0]      wlen_sel,
    output logic [WMAX-1:0] left_out,
    output logic [WMAX-1:0] right_out,
    output logic            valid_out
);
    logic            edge_tick;
    logic            edge_lr;
    logic            edge_d;
    logic            close_stb;
    logic            close_chan;
    logic [WMAX-1:0] close_word;
    fmt_e            fmt;

    // Interpret the format select as the shared enum.
    always_comb fmt = fmt_e'(fmt_sel);

    audrx_edge #(.SYNC(SYNC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_in),
        .lrclk_in (lrclk_in),
        .data_in  (data_in),
        .tick     (edge_tick),
        .lr_s     (edge_lr),
        .d_s      (edge_d)
    );

    audrx_shift #(.WMAX(WMAX)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (edge_tick),
        .lr         (edge_lr),
        .d          (edge_d),
        .fmt        (fmt),
        .wlen       (wlen_sel),
        .close_stb  (close_stb),
        .close_chan (close_chan),
        .close_word (close_word)
    );

    audrx_pair #(.WMAX(WMAX)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .close_stb  (close_stb),
        .close_chan (close_chan),
        .close_word (close_word),
        .left_out   (left_out),
        .right_out  (right_out),
        .valid_out  (valid_out)
    );

endmodule

// File: rtl/audrx_checker.sv
// Property checker for the audio serial receiver, bound to the top.
module audrx_checker
    import audrx_pkg::*;
#(
    parameter int WMAX = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      wlen_sel,
    input logic [WMAX-1:0] left_out,
    input logic [WMAX-1:0] right_out,
    input logic            valid_out,
    input logic            tick
);
    logic [WMAX-1:0] lim;

    // Mask of bits allowed by the current word length.
    always_comb lim = WMAX'(low_mask(wlen_bits(wlen_sel)));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && left_out == '0 && right_out == '0)); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out); // R2

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> ($stable(left_out) && $stable(right_out))); // R2

    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> $past(tick, 2)); // R2

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (((left_out & ~lim) == '0) && ((right_out & ~lim) == '0))); // R10

endmodule

bind audrx_serial_rx audrx_checker #(.WMAX(WMAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wlen_sel  (wlen_sel),
    .left_out  (left_out),
    .right_out (right_out),
    .valid_out (valid_out),
    .tick      (edge_tick)
);

// File: tb/sim_audrx_serial_rx.sv
module sim_audrx_serial_rx;
    localparam int W      = 32;
    localparam int HALF   = 3;
    localparam int MAXLEN = 2048;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bclk, lrc, din;
    logic [1:0]   fmt, wlen;
    logic [W-1:0] left_out, right_out;
    logic         valid_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic bit_a [MAXLEN];
    logic lr_a  [MAXLEN];
    int   len;
    logic [31:0] el[$], er[$], gl[$], gr[$];
    int   dbl_valid;
    logic prev_valid;

    always #5 clk = ~clk;

    audrx_serial_rx #(.WMAX(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrclk_in(lrc),
        .data_in(din), .fmt_sel(fmt), .wlen_sel(wlen),
        .left_out(left_out), .right_out(right_out), .valid_out(valid_out)
    );

    // Collect output pairs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid_out) begin
            gl.push_back(left_out);
            gr.push_back(right_out);
            if (prev_valid) dbl_valid++;
        end
        prev_valid = rst_n && valid_out;
    end

    function automatic logic [31:0] lmask(input int n);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic int nfor(input logic [1:0] c);
        case (c)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic seg(input logic lv, input int n);
        for (int i = 0; i < n; i++) begin
            lr_a[len] = lv;
            len++;
        end
    endtask

    task automatic place(input int start, input logic [31:0] w, input int n, input int k);
        for (int i = 0; i < k; i++) bit_a[start + i] = w[n - 1 - i];
    endtask

    task automatic start_test(input logic [1:0] f, input logic [1:0] wl);
        fmt = f; wlen = wl; len = 0;
        for (int i = 0; i < MAXLEN; i++) begin
            bit_a[i] = 1'($urandom % 2);
            lr_a[i]  = 1'b0;
        end
        el.delete(); er.delete(); gl.delete(); gr.delete();
        dbl_valid = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(valid_out == 1'b0 && left_out == '0 && right_out == '0, "R1", "reset state",
            left_out | right_out | 32'(valid_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_out == 1'b0 && left_out == '0 && right_out == '0, "R1", "after release",
            left_out | right_out | 32'(valid_out), 32'h0);
    endtask

    task automatic play();
        for (int i = 0; i < len; i++) begin
            bclk = 1'b0; lrc = lr_a[i]; din = bit_a[i];
            repeat (HALF) @(negedge clk);
            bclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        bclk = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic end_test(input string req);
        play();
        chk(gl.size() == el.size(), req, "pair count", 32'(gl.size()), 32'(el.size()));
        chk(dbl_valid == 0, "R2", "valid width", 32'(dbl_valid), 32'h0);
        for (int i = 0; i < el.size() && i < gl.size(); i++) begin
            chk(gl[i] == el[i], req, $sformatf("left word %0d", i), gl[i], el[i]);
            chk(gr[i] == er[i], req, $sformatf("right word %0d", i), gr[i], er[i]);
        end
    endtask

    // Right justified: word at the end of each half, lr high = left.
    task automatic rj_frame(input int n, input int h, input logic [31:0] lw, input logic [31:0] rw);
        int base = len;
        seg(1'b1, h); seg(1'b0, h);
        place(base + h - n, lw, n, n);
        place(base + 2*h - n, rw, n, n);
        el.push_back(lw & lmask(n)); er.push_back(rw & lmask(n));
    endtask

    // I2S: MSB one bit after the change, lr low = left.
    task automatic i2s_frame(input int n, input int h, input logic [31:0] lw, input logic [31:0] rw);
        int base = len;
        int k = (h < n) ? h : n;
        logic [31:0] keep = lmask(n) & ~lmask(n - k);
        seg(1'b0, h); seg(1'b1, h);
        place(base + 1, lw, n, k);
        place(base + h + 1, rw, n, k);
        el.push_back(lw & keep); er.push_back(rw & keep);
    endtask

    // Frame pulse: left at pulse (early) or one bit later, right right after.
    task automatic dsp_frame(input bit early, input int f, input int p, input int n,
                             input logic [31:0] lw, input logic [31:0] rw);
        int base = len;
        int s = base + (early ? 0 : 1);
        seg(1'b1, p); seg(1'b0, f - p);
        place(s, lw, n, n);
        place(s + n, rw, n, n);
        el.push_back(lw & lmask(n)); er.push_back(rw & lmask(n));
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bclk = 1'b0; lrc = 1'b0; din = 1'b0; fmt = 2'd0; wlen = 2'd0;
        len = 0; prev_valid = 1'b0;

        // R3 right justified, exact half-frames, 16 bits
        start_test(2'd0, 2'd0);
        seg(1'b0, 3);
        for (int i = 0; i < 4; i++) rj_frame(16, 16, $urandom, $urandom);
        seg(1'b1, 2);
        end_test("R3");

        // R4 right justified with leading junk bits, 24 bits
        start_test(2'd0, 2'd2);
        seg(1'b0, 3);
        for (int i = 0; i < 5; i++) rj_frame(24, 24 + int'($urandom % 12), $urandom, $urandom);
        seg(1'b1, 2);
        end_test("R4");

        // R10 right justified, 32 bits, directed edge words
        start_test(2'd0, 2'd3);
        seg(1'b0, 3);
        rj_frame(32, 34, 32'h8000_0001, 32'hFFFF_FFFF);
        rj_frame(32, 32, 32'h5555_AAAA, 32'h0000_0001);
        seg(1'b1, 2);
        end_test("R10");

        // R10 right justified, 20 bits, upper bits of words must be cleared
        start_test(2'd0, 2'd1);
        seg(1'b0, 3);
        for (int i = 0; i < 3; i++) rj_frame(20, 20 + int'($urandom % 5), $urandom | 32'hFFF0_0000, $urandom);
        seg(1'b1, 2);
        end_test("R10");

        // R5 I2S exact half-frames, 16 bits
        start_test(2'd1, 2'd0);
        seg(1'b1, 3);
        for (int i = 0; i < 4; i++) i2s_frame(16, 16, $urandom, $urandom);
        seg(1'b0, 3);
        end_test("R5");

        // R5 I2S directed corner words, 24 bits
        start_test(2'd1, 2'd2);
        seg(1'b1, 3);
        i2s_frame(24, 24, 32'h0080_0001, 32'h007F_FFFE);
        i2s_frame(24, 25, 32'h00AA_AA55, 32'h0000_0000);
        seg(1'b0, 3);
        end_test("R5");

        // R6 I2S surplus bits discarded, 20 bits in 32-bit halves
        start_test(2'd1, 2'd1);
        seg(1'b1, 3);
        for (int i = 0; i < 4; i++) i2s_frame(20, 32, $urandom, $urandom);
        seg(1'b0, 3);
        end_test("R6");

        // R6 I2S short halves zero padded, 32 bits in 20..23 bit halves
        start_test(2'd1, 2'd3);
        seg(1'b1, 3);
        for (int i = 0; i < 4; i++) i2s_frame(32, 20 + int'($urandom % 4), $urandom, $urandom);
        seg(1'b0, 3);
        end_test("R6");

        // R7 early frame pulse, one-bit pulse, 16 bits
        start_test(2'd3, 2'd0);
        seg(1'b0, 3);
        for (int i = 0; i < 4; i++) dsp_frame(1'b1, 40, 1, 16, $urandom, $urandom);
        seg(1'b0, 2);
        end_test("R7");

        // R8 late frame pulse, random pulse widths, 16 bits
        start_test(2'd2, 2'd0);
        seg(1'b0, 3);
        for (int i = 0; i < 4; i++) dsp_frame(1'b0, 40, 1 + int'($urandom % 38), 16, $urandom, $urandom);
        seg(1'b0, 2);
        end_test("R8");

        // R9 early pulse, 32 bits, varying idle tails and pulse widths
        start_test(2'd3, 2'd3);
        seg(1'b0, 3);
        for (int i = 0; i < 4; i++) begin
            int f = 66 + int'($urandom % 10);
            dsp_frame(1'b1, f, 1 + int'($urandom % (f - 2)), 32, $urandom, $urandom);
        end
        seg(1'b0, 2);
        end_test("R9");

        // R9 late pulse, 24 bits, long pulse and idle gap
        start_test(2'd2, 2'd2);
        seg(1'b0, 3);
        for (int i = 0; i < 3; i++) dsp_frame(1'b0, 64, 20, 24, $urandom, $urandom);
        dsp_frame(1'b0, 64, 62, 24, 32'h00FF_0001, 32'h0080_0000);
        seg(1'b0, 2);
        end_test("R9");

        finish_run();
    end

endmodule